// File: doc/BRIEF.md
# Banked General Register File with Exception Context

This block holds the sixteen 32-bit general registers of a processor core, along with its status word, a vector base register and three shadow registers that capture machine context when an exception is taken. The lower eight registers have two physical copies. Which copy an access reaches is chosen from two status bits: the privilege bit and the bank-select bit. Registers eight to fifteen have only one copy. Instruction decode and the execution units sit outside the block. They reach it through two combinational read ports and one synchronous write port.

When an exception is taken, the block does four things at one clock edge. It stores the faulting program counter, the current status word and register 15 in the shadow registers. It raises the privilege, bank-select and event-block bits. It sends the fetch unit a redirect to the vector base plus a supplied offset. Because of the bank switch, a handler writing its low registers does not overwrite the interrupted program's copies. A return request copies the saved status back and redirects fetch to the saved program counter. When reset releases, the block redirects fetch to a fixed start address.

Top module: `banked_gpr_ctx`

## Requirements
- R1: Reset gives the following state, visible in the first cycle after reset is released:
  - status reads 0x7000_00F0, with the FPU-disable bit (bit 15) clear;
  - every general register reads zero;
  - saved PC, saved status, saved R15 and vector base read zero;
  - `redirect_valid` is 1 and `redirect_pc` is 0xA000_0000.
- R2: Registers 8 to 15 are a single shared set. A value written to one of them reads back the same whatever the status bits are.
- R3: When the privilege bit (status bit 30) is 0, registers 0 to 7 always use bank 0, whatever bank-select (bit 29) holds. Bank 1 cannot be read or written in this mode.
- R4: When status bit 30 is 1, registers 0 to 7 use bank 0 if bit 29 is 0 and bank 1 if bit 29 is 1.
- R5: A read returns the register contents from before the current clock edge. A read of the register being written in the same cycle returns the old value, and the new value shows from the next cycle on.
- R6: A status write stores only bits 0, 1, 4 to 9, 15, 28, 29 and 30 (mask 0x7000_83F3). All other status bits always read 0.
- R7: When an exception is taken, the following happen at the same edge:
  - saved PC takes `exc_pc`;
  - saved status takes the status word;
  - saved R15 takes register 15 as it stood before that edge;
  - status bits 28, 29 and 30 are set to 1, and all other status bits are kept.
- R8: In the cycle after an exception is taken, `redirect_valid` is 1 and `redirect_pc` equals the vector base plus the zero-extended `exc_vofs`. In a cycle after neither an exception nor a return, `redirect_valid` is 0.
- R9: A return request without an exception loads the saved status into the status register. In the next cycle it drives `redirect_valid`=1 and `redirect_pc` = saved PC.
- R10: Priority and write bank:
  - an exception overrides a return and a status write in the same cycle;
  - a return overrides a status write;
  - a general-register write in the exception cycle goes to the bank selected before entry.
- R11: A vector-base write takes effect at the next edge. An exception in the same cycle uses the old vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General-register write enable |
| wr_idx | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| sr_wr_en | input | 1 | Status write enable |
| sr_wr_data | input | 32 | Status write data |
| vbr_wr_en | input | 1 | Vector base write enable |
| vbr_wr_data | input | 32 | Vector base write data |
| exc_take | input | 1 | Take an exception this cycle |
| exc_vofs | input | VOFS_W | Vector offset added to the vector base |
| exc_pc | input | 32 | Program counter of the faulting instruction |
| rte | input | 1 | Return from exception |
| sr_q | output | 32 | Status register |
| spc_q | output | 32 | Saved program counter |
| ssr_q | output | 32 | Saved status |
| sgr_q | output | 32 | Saved register 15 |
| vbr_q | output | 32 | Vector base register |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Fetch redirect target |

## Verification
The bench aims at cycles where several things happen at once: an exception that coincides with a return, a status write, a vector-base write, and a write to register 15 or to a low register.

- A design that gave a return priority over an exception would lose the saved context.
- A design that let the register write run ahead of the save would capture the new value of register 15 instead of the old one.
- A design that took the write bank from the post-entry status would corrupt bank 1 when the program expected bank 0.

The bench toggles bank-select while in user mode, to catch a design that ignores the privilege bit and exposes bank 1. It also writes all ones to the status register, to catch reserved bits that are not masked.

// File: rtl/gprb_pkg.sv
package gprb_pkg;

    localparam int WORD_W       = 32;
    localparam int GPR_COUNT    = 16;
    localparam int BANKED_COUNT = 8;
    localparam int SHARED_COUNT = GPR_COUNT - BANKED_COUNT;
    localparam int IDX_W        = $clog2(GPR_COUNT);
    localparam int LOW_W        = $clog2(BANKED_COUNT);
    localparam int SH_W         = $clog2(SHARED_COUNT);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  gidx_t;

    // status bit positions
    localparam int SR_T       = 0;
    localparam int SR_SAT     = 1;
    localparam int SR_IMSK_LO = 4;
    localparam int SR_IMSK_HI = 7;
    localparam int SR_QD      = 8;
    localparam int SR_MD_DIV  = 9;
    localparam int SR_FPOFF   = 15;
    localparam int SR_BLK     = 28;
    localparam int SR_BANK    = 29;
    localparam int SR_PRIV    = 30;

    function automatic word_t build_legal_mask();
        word_t m;
        m = '0;
        m[SR_T]      = 1'b1;
        m[SR_SAT]    = 1'b1;
        for (int i = SR_IMSK_LO; i <= SR_IMSK_HI; i++) m[i] = 1'b1;
        m[SR_QD]     = 1'b1;
        m[SR_MD_DIV] = 1'b1;
        m[SR_FPOFF]  = 1'b1;
        m[SR_BLK]    = 1'b1;
        m[SR_BANK]   = 1'b1;
        m[SR_PRIV]   = 1'b1;
        return m;
    endfunction

    function automatic word_t build_entry_set();
        word_t m;
        m = '0;
        m[SR_BLK]  = 1'b1;
        m[SR_BANK] = 1'b1;
        m[SR_PRIV] = 1'b1;
        return m;
    endfunction

    function automatic word_t build_reset_sr();
        word_t m;
        m = build_entry_set();
        for (int i = SR_IMSK_LO; i <= SR_IMSK_HI; i++) m[i] = 1'b1;
        m[SR_FPOFF] = 1'b0;
        return m;
    endfunction

    localparam word_t SR_LEGAL     = build_legal_mask();
    localparam word_t SR_ENTRY_SET = build_entry_set();
    localparam word_t SR_RESET     = build_reset_sr();

    // saved machine context
    typedef struct packed {
        word_t pc;
        word_t sr;
        word_t sp;
    } ctx_t;

    typedef enum logic [1:0] {
        CTL_NONE,
        CTL_ENTER,
        CTL_RETURN,
        CTL_SRWRITE
    } ctl_op_t;

    function automatic logic alt_bank(input word_t sr);
        return sr[SR_PRIV] & sr[SR_BANK];
    endfunction

    function automatic word_t sr_clean(input word_t v);
        return v & SR_LEGAL;
    endfunction

    function automatic ctl_op_t pick_op(input logic exc, input logic ret, input logic srw);
        if (exc)      return CTL_ENTER;
        else if (ret) return CTL_RETURN;
        else if (srw) return CTL_SRWRITE;
        else          return CTL_NONE;
    endfunction

endpackage

// File: rtl/gprb_bank_array.sv
module gprb_bank_array
    import gprb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  gidx_t wr_idx,
    input  word_t wr_data,
    input  logic  wr_alt,
    output word_t [BANKED_COUNT-1:0] low0_q,
    output word_t [BANKED_COUNT-1:0] low1_q,
    output word_t [SHARED_COUNT-1:0] high_q
);

    word_t bank0_r [BANKED_COUNT];
    word_t bank1_r [BANKED_COUNT];
    word_t share_r [SHARED_COUNT];

    for (genvar k = 0; k < BANKED_COUNT; k++) begin : g_low
        always_ff @(posedge clk) begin
            if (rst) begin
                bank0_r[k] <= '0;
                bank1_r[k] <= '0;
            end else if (wr_en && wr_idx == gidx_t'(k)) begin
                if (wr_alt) bank1_r[k] <= wr_data;
                else        bank0_r[k] <= wr_data;
            end
        end
        assign low0_q[k] = bank0_r[k];
        assign low1_q[k] = bank1_r[k];
    end

    for (genvar k = 0; k < SHARED_COUNT; k++) begin : g_high
        always_ff @(posedge clk) begin
            if (rst) begin
                share_r[k] <= '0;
            end else if (wr_en && wr_idx == gidx_t'(BANKED_COUNT + k)) begin
                share_r[k] <= wr_data;
            end
        end
        assign high_q[k] = share_r[k];
    end

endmodule

// File: rtl/gprb_read_mux.sv
module gprb_read_mux
    import gprb_pkg::*;
(
    input  gidx_t idx,
    input  logic  alt,
    input  word_t [BANKED_COUNT-1:0] low0,
    input  word_t [BANKED_COUNT-1:0] low1,
    input  word_t [SHARED_COUNT-1:0] high,
    output word_t data
);

    logic [LOW_W-1:0] lsel;
    logic [SH_W-1:0]  hsel;
    gidx_t            hoff;

    assign hoff = idx - gidx_t'(BANKED_COUNT);
    assign lsel = idx[LOW_W-1:0];
    assign hsel = hoff[SH_W-1:0];

    always_comb begin
        if (idx < gidx_t'(BANKED_COUNT)) begin
            data = alt ? low1[lsel] : low0[lsel];
        end else begin
            data = high[hsel];
        end
    end

endmodule

// File: rtl/gprb_ctx_ctrl.sv
module gprb_ctx_ctrl
    import gprb_pkg::*;
#(
    parameter int    VOFS_W       = 12,
    parameter word_t RESET_VECTOR = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_take,
    input  logic [VOFS_W-1:0] exc_vofs,
    input  word_t             exc_pc,
    input  logic              rte,
    input  logic              sr_wr_en,
    input  word_t             sr_wr_data,
    input  logic              vbr_wr_en,
    input  word_t             vbr_wr_data,
    input  word_t             r15_val,
    output word_t             sr_q,
    output ctx_t              saved_q,
    output word_t             vbr_q,
    output logic              redir_valid,
    output word_t             redir_pc
);

    ctl_op_t op;
    assign op = pick_op(exc_take, rte, sr_wr_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q        <= SR_RESET;
            saved_q     <= '0;
            redir_valid <= 1'b1;
            redir_pc    <= RESET_VECTOR;
        end else begin
            unique case (op)
                CTL_ENTER: begin
                    saved_q.pc  <= exc_pc;
                    saved_q.sr  <= sr_q;
                    saved_q.sp  <= r15_val;
                    sr_q        <= sr_q | SR_ENTRY_SET;
                    redir_valid <= 1'b1;
                    redir_pc    <= vbr_q + word_t'(exc_vofs);
                end
                CTL_RETURN: begin
                    sr_q        <= saved_q.sr;
                    redir_valid <= 1'b1;
                    redir_pc    <= saved_q.pc;
                end
                CTL_SRWRITE: begin
                    sr_q        <= sr_clean(sr_wr_data);
                    redir_valid <= 1'b0;
                end
                default: begin
                    redir_valid <= 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            vbr_q <= '0;
        else if (vbr_wr_en) vbr_q <= vbr_wr_data;
    end

endmodule

// File: rtl/banked_gpr_ctx.sv
module banked_gpr_ctx
    import gprb_pkg::*;
#(
    parameter int          VOFS_W       = 12,
    parameter logic [31:0] RESET_VECTOR = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        rd_a_idx,
    output logic [31:0]       rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [31:0]       rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              sr_wr_en,
    input  logic [31:0]       sr_wr_data,
    input  logic              vbr_wr_en,
    input  logic [31:0]       vbr_wr_data,
    input  logic              exc_take,
    input  logic [VOFS_W-1:0] exc_vofs,
    input  logic [31:0]       exc_pc,
    input  logic              rte,
    output logic [31:0]       sr_q,
    output logic [31:0]       spc_q,
    output logic [31:0]       ssr_q,
    output logic [31:0]       sgr_q,
    output logic [31:0]       vbr_q,
    output logic              redirect_valid,
    output logic [31:0]       redirect_pc
);

    localparam int NUM_RD = 2;

    word_t [BANKED_COUNT-1:0] low0, low1;
    word_t [SHARED_COUNT-1:0] high;
    word_t  status;
    ctx_t   saved;
    logic   use_alt;
    gidx_t  rd_idx [NUM_RD];
    word_t  rd_val [NUM_RD];

    assign use_alt = alt_bank(status);

    gprb_bank_array u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_alt  (use_alt),
        .low0_q  (low0),
        .low1_q  (low1),
        .high_q  (high)
    );

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gprb_read_mux u_mux (
            .idx  (rd_idx[p]),
            .alt  (use_alt),
            .low0 (low0),
            .low1 (low1),
            .high (high),
            .data (rd_val[p])
        );
    end

    assign rd_a_data = rd_val[0];
    assign rd_b_data = rd_val[1];

    gprb_ctx_ctrl #(
        .VOFS_W       (VOFS_W),
        .RESET_VECTOR (RESET_VECTOR)
    ) u_ctx (
        .clk         (clk),
        .rst         (rst),
        .exc_take    (exc_take),
        .exc_vofs    (exc_vofs),
        .exc_pc      (exc_pc),
        .rte         (rte),
        .sr_wr_en    (sr_wr_en),
        .sr_wr_data  (sr_wr_data),
        .vbr_wr_en   (vbr_wr_en),
        .vbr_wr_data (vbr_wr_data),
        .r15_val     (high[SHARED_COUNT-1]),
        .sr_q        (status),
        .saved_q     (saved),
        .vbr_q       (vbr_q),
        .redir_valid (redirect_valid),
        .redir_pc    (redirect_pc)
    );

    assign sr_q  = status;
    assign spc_q = saved.pc;
    assign ssr_q = saved.sr;
    assign sgr_q = saved.sp;

endmodule

// File: rtl/banked_gpr_ctx_chk.sv
module banked_gpr_ctx_chk
    import gprb_pkg::*;
#(
    parameter int VOFS_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              exc_take,
    input logic [VOFS_W-1:0] exc_vofs,
    input logic [31:0]       exc_pc,
    input logic              rte,
    input logic              sr_wr_en,
    input logic [31:0]       sr_wr_data,
    input logic [31:0]       sr_q,
    input logic [31:0]       spc_q,
    input logic [31:0]       ssr_q,
    input logic [31:0]       vbr_q,
    input logic              redirect_valid,
    input logic [31:0]       redirect_pc
);

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst) (sr_q & ~SR_LEGAL) == 32'h0); // R6
    AST_SR_WR_MASK: assert property (@(posedge clk) disable iff (rst) (sr_wr_en && !exc_take && !rte) |=> sr_q == ($past(sr_wr_data) & SR_LEGAL)); // R6
    AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (rst) exc_take |=> (spc_q == $past(exc_pc)) && (ssr_q == $past(sr_q))); // R7
    AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (rst) exc_take |=> sr_q[30:28] == 3'b111); // R7
    AST_ENTRY_TARGET: assert property (@(posedge clk) disable iff (rst) exc_take |=> redirect_valid && redirect_pc == ($past(vbr_q) + 32'($past(exc_vofs)))); // R8
    AST_QUIET_REDIRECT: assert property (@(posedge clk) disable iff (rst) (!exc_take && !rte) |=> !redirect_valid); // R8
    AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (rst) (rte && !exc_take) |=> sr_q == $past(ssr_q) && redirect_valid && redirect_pc == $past(spc_q)); // R9

endmodule

bind banked_gpr_ctx banked_gpr_ctx_chk #(.VOFS_W(VOFS_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .exc_take       (exc_take),
    .exc_vofs       (exc_vofs),
    .exc_pc         (exc_pc),
    .rte            (rte),
    .sr_wr_en       (sr_wr_en),
    .sr_wr_data     (sr_wr_data),
    .sr_q           (sr_q),
    .spc_q          (spc_q),
    .ssr_q          (ssr_q),
    .vbr_q          (vbr_q),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
);

// File: tb/banked_gpr_ctx_bench.sv
module banked_gpr_ctx_bench;

    localparam int VW = 12;
    localparam logic [31:0] LEGAL = 32'h7000_83F3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0, sr_wr_en = 1'b0, vbr_wr_en = 1'b0, exc_take = 1'b0, rte = 1'b0;
    logic [31:0] wr_data = '0, sr_wr_data = '0, vbr_wr_data = '0, exc_pc = '0;
    logic [VW-1:0] exc_vofs = '0;
    logic [31:0] sr_q, spc_q, ssr_q, sgr_q, vbr_q, redirect_pc;
    logic        redirect_valid;

    always #4 clk = ~clk;

    banked_gpr_ctx #(.VOFS_W(VW)) u_banked_gpr_ctx (.*);

    int nvec = 0;
    int nmis = 0;

    logic [31:0] m_b0 [8];
    logic [31:0] m_b1 [8];
    logic [31:0] m_hi [8];
    logic [31:0] m_sr, m_spc, m_ssr, m_sgr, m_vbr, m_rpc;
    logic        m_rv;

    function automatic logic [31:0] m_read(input logic [3:0] idx);
        if (idx < 8) return (m_sr[30] && m_sr[29]) ? m_b1[idx[2:0]] : m_b0[idx[2:0]];
        return m_hi[idx[2:0]];
    endfunction

    task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_b0[i] = '0; m_b1[i] = '0; m_hi[i] = '0;
        end
        m_sr = 32'h7000_00F0; m_spc = '0; m_ssr = '0; m_sgr = '0; m_vbr = '0;
        m_rv = 1'b1; m_rpc = 32'hA000_0000;
    endtask

    task automatic model_clock();
        logic [31:0] old_sr, old15, old_vbr;
        logic alt;
        old_sr = m_sr; old15 = m_hi[7]; old_vbr = m_vbr;
        alt = old_sr[30] && old_sr[29];
        if (wr_en) begin
            if (wr_idx < 8) begin
                if (alt) m_b1[wr_idx[2:0]] = wr_data;
                else     m_b0[wr_idx[2:0]] = wr_data;
            end else begin
                m_hi[wr_idx[2:0]] = wr_data;
            end
        end
        if (exc_take) begin
            m_ssr = old_sr; m_spc = exc_pc; m_sgr = old15;
            m_sr = old_sr | 32'h7000_0000;
            m_rv = 1'b1; m_rpc = old_vbr + {20'h0, exc_vofs};
        end else if (rte) begin
            m_sr = m_ssr; m_rv = 1'b1; m_rpc = m_spc;
        end else begin
            if (sr_wr_en) m_sr = sr_wr_data & LEGAL;
            m_rv = 1'b0;
        end
        if (vbr_wr_en) m_vbr = vbr_wr_data;
    endtask

    task automatic step(input string tag);
        #1;
        chk(tag, "rd_a", rd_a_data, m_read(rd_a_idx));
        chk(tag, "rd_b", rd_b_data, m_read(rd_b_idx));
        chk(tag, "sr", sr_q, m_sr);
        chk(tag, "spc", spc_q, m_spc);
        chk(tag, "ssr", ssr_q, m_ssr);
        chk(tag, "sgr", sgr_q, m_sgr);
        chk(tag, "vbr", vbr_q, m_vbr);
        chk(tag, "redirect_valid", {31'h0, redirect_valid}, {31'h0, m_rv});
        if (m_rv) chk(tag, "redirect_pc", redirect_pc, m_rpc);
        model_clock();
        @(negedge clk);
        #1;
    endtask

    task automatic clr();
        wr_en = 0; sr_wr_en = 0; vbr_wr_en = 0; exc_take = 0; rte = 0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d, input string tag);
        clr(); wr_en = 1; wr_idx = idx; wr_data = d; rd_a_idx = idx; rd_b_idx = idx;
        step(tag);
        clr();
    endtask

    task automatic srw(input logic [31:0] d, input string tag);
        clr(); sr_wr_en = 1; sr_wr_data = d; step(tag); clr();
    endtask

    task automatic read_all(input string tag);
        clr();
        for (int i = 0; i < 16; i += 2) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(i + 1); step(tag);
        end
    endtask

    initial begin
        #(8 * 150000);
        nmis++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;

        // R1 reset state, redirect to start address
        rd_a_idx = 0; rd_b_idx = 15; step("R1");
        read_all("R1");

        // R4 privileged, bank-select 1 after reset: fill bank 1 and shared set
        for (int i = 0; i < 16; i++) wr(4'(i), 32'h1100_0000 + 32'(i), "R4");
        // R5 read of same register during its write returns old value
        wr(4'd3, 32'hDEAD_0003, "R5");
        rd_a_idx = 3; step("R5");
        // R4 bank 0 in privileged mode with bank-select 0
        srw(32'h4000_0000, "R4");
        for (int i = 0; i < 8; i++) wr(4'(i), 32'h0B00_0000 + 32'(i), "R4");
        read_all("R2");
        // R3 user mode ignores bank-select
        srw(32'h2000_0000, "R3");
        read_all("R3");
        wr(4'd2, 32'h0005_E002, "R3");
        wr(4'd9, 32'h0005_E009, "R2");
        srw(32'h6000_0000, "R3");
        read_all("R3");
        // R6 reserved bits masked
        srw(32'hFFFF_FFFF, "R6");
        srw(32'h8F0F_7C0C, "R6");
        srw(32'h0000_0001, "R6");
        // R11 vector base write
        clr(); vbr_wr_en = 1; vbr_wr_data = 32'h8C00_0000; step("R11"); clr();
        // R10 exception from user mode with collisions: rte, sr write, gpr write to r1, vbr write
        clr(); exc_take = 1; exc_vofs = 12'h600; exc_pc = 32'h0C00_1234; rte = 1;
        sr_wr_en = 1; sr_wr_data = 32'h0; wr_en = 1; wr_idx = 1; wr_data = 32'hAAAA_0001;
        vbr_wr_en = 1; vbr_wr_data = 32'h9000_0000;
        step("R10"); clr();
        read_all("R7");
        // R7 exception capturing r15 while r15 written
        wr(4'd0, 32'h4A4D_0000, "R4");
        clr(); wr_en = 1; wr_idx = 15; wr_data = 32'h5555_000F; exc_take = 1;
        exc_vofs = 12'h100; exc_pc = 32'h0C00_2000; step("R7"); clr();
        step("R8");
        // R9 return restores status and redirects to saved PC
        clr(); rte = 1; step("R9"); clr();
        step("R9");
        read_all("R9");
        // R10 return beats status write
        clr(); rte = 1; sr_wr_en = 1; sr_wr_data = 32'h4000_0000; step("R10"); clr();
        step("R10");

        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            clr();
            rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
            wr_en = ($urandom % 2) == 0; wr_idx = 4'($urandom); wr_data = $urandom;
            sr_wr_en = ($urandom % 6) == 0; sr_wr_data = $urandom;
            vbr_wr_en = ($urandom % 10) == 0; vbr_wr_data = $urandom;
            exc_take = ($urandom % 12) == 0; exc_vofs = VW'($urandom); exc_pc = $urandom;
            rte = ($urandom % 10) == 0;
            step("R4");
        end
        clr();
        step("R8");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

endmodule